// File: doc/BRIEF.md
# Single-Channel Word-Streaming DMA

This block moves a block of 32-bit words from memory to a streaming endpoint. Software programs a start address and a word count through a small register window, then sets a start bit. The engine issues one memory read at a time and waits for the word to come back on a valid strobe. It places each word on an endpoint stream and holds it there until the endpoint accepts it. Only then does it fetch the next word, four bytes further on.

When the block is exhausted the engine raises a one-cycle completion interrupt. It bumps a completion tally that software can read back, and it emits a one-cycle event that carries the job's start address and length. A busy output covers the whole job. While busy, the register window refuses writes, so a job in flight cannot be disturbed. A zero-length job is legal. It finishes at once and still counts as a completion.

Top module: `wordstream_dma`

## Requirements
- R1: Register window (byte offsets on `cfg_ofs`): 0x0 start address, 0x4 word count (low 16 bits), 0x8 control, 0xC completion tally. A read strobe returns data on `cfg_rdata` with `cfg_rvalid` high in the next cycle. Control reads back busy in bit 0, and any other offset reads as zero.
- R2: A write of 1 in bit 0 of the control register while idle starts a job. `busy` is high from the cycle after that write until the cycle in which `irq_done` pulses.
- R3: The engine issues one-cycle `mem_rd_en` requests at start address, +4, +8, and so on. It has at most one read outstanding, and it issues the next request only after the previous word has been accepted by the endpoint.
- R4: Each returned word appears on `ep_data` with `ep_valid`. Data and `ep_last` stay stable while `ep_ready` is low, and `ep_last` is high only on the final word of a job.
- R5: At the end of a job, `irq_done` and `evt_valid` pulse for exactly one cycle, in the cycle in which `busy` falls. The tally rises by one, and `evt_base`/`evt_len` give the job's start address and word count.
- R6: Register writes that arrive while `busy` is high are ignored, including a second start.
- R7: A word count of zero completes with no memory request and no stream beat. `irq_done` pulses two cycles after the start write, and the tally still rises by one.
- R8: Synchronous active-high reset, even in the middle of a job, clears `busy`, the stream, the memory request, the pulses, the registers and the tally.
- R9: A control write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_ofs | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| mem_rd_en | output | 1 | Memory read request pulse |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_data | input | 32 | Memory read data |
| mem_rd_valid | input | 1 | Memory read data valid |
| ep_valid | output | 1 | Stream word valid |
| ep_data | output | 32 | Stream word |
| ep_last | output | 1 | Final word of the job |
| ep_ready | input | 1 | Endpoint accepts the word |
| busy | output | 1 | Job in progress |
| irq_done | output | 1 | Completion interrupt pulse |
| evt_valid | output | 1 | Completion event pulse |
| evt_base | output | 32 | Start address of the finished job |
| evt_len | output | 16 | Word count of the finished job |

## Verification
A bad remaining-word count shows at the ports on the word where it matters. `ep_last` lands on the wrong beat, an extra or missing `mem_rd_en` pulse appears, and `irq_done` fires early or late. The per-cycle model comparison catches each of these in that same cycle. A corrupt address counter shows on the very next request address. A tally or register fault stays hidden until the next read, so the bench reads the window back after every job and after every write refused while busy.

// File: rtl/wsd_pkg.sv
package wsd_pkg;
  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_WAIT = 2'd1,
    MV_SEND = 2'd2,
    MV_FIN  = 2'd3
  } mv_state_e;

  localparam logic [3:0] OFS_BASE  = 4'h0;
  localparam logic [3:0] OFS_WORDS = 4'h4;
  localparam logic [3:0] OFS_CTRL  = 4'h8;
  localparam logic [3:0] OFS_TALLY = 4'hC;
endpackage

// File: rtl/wsd_cfg_regs.sv
module wsd_cfg_regs #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  input  logic [CNT_W-1:0] tally,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic [AW-1:0]    base,
  output logic [LEN_W-1:0] words,
  output logic             start
);
  import wsd_pkg::*;

  logic wr_ok;
  assign wr_ok = wr_en && !busy;
  assign start = wr_ok && (ofs == OFS_W'(OFS_CTRL)) && wdata[0];

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_W'(OFS_BASE):  rd_mux = DW'(base);
      OFS_W'(OFS_WORDS): rd_mux = DW'(words);
      OFS_W'(OFS_CTRL):  rd_mux = DW'(busy);
      OFS_W'(OFS_TALLY): rd_mux = DW'(tally);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      words  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
      if (wr_ok && ofs == OFS_W'(OFS_BASE))  base  <= AW'(wdata);
      if (wr_ok && ofs == OFS_W'(OFS_WORDS)) words <= wdata[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/wsd_mover.sv
module wsd_mover #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] words,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [DW-1:0]    mem_rd_data,
  input  logic             mem_rd_valid,
  output logic             ep_valid,
  output logic [DW-1:0]    ep_data,
  output logic             ep_last,
  input  logic             ep_ready,
  output logic             busy,
  output logic             fin
);
  import wsd_pkg::*;

  localparam int          STEP_BYTES = DW / 8;
  localparam logic [AW-1:0] STEP     = AW'(STEP_BYTES);

  mv_state_e        state;
  logic [LEN_W-1:0] left;

  assign fin = (state == MV_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= MV_IDLE;
      left        <= '0;
      busy        <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      ep_valid    <= 1'b0;
      ep_data     <= '0;
      ep_last     <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      case (state)
        MV_IDLE: if (start) begin
          busy <= 1'b1;
          left <= words;
          if (words == '0) begin
            state <= MV_FIN;
          end else begin
            state       <= MV_WAIT;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= base;
          end
        end
        MV_WAIT: if (mem_rd_valid) begin
          ep_valid <= 1'b1;
          ep_data  <= mem_rd_data;
          ep_last  <= (left == LEN_W'(1));
          state    <= MV_SEND;
        end
        MV_SEND: if (ep_ready) begin
          ep_valid <= 1'b0;
          ep_last  <= 1'b0;
          if (left == LEN_W'(1)) begin
            state <= MV_FIN;
          end else begin
            left        <= left - LEN_W'(1);
            mem_rd_addr <= mem_rd_addr + STEP;
            mem_rd_en   <= 1'b1;
            state       <= MV_WAIT;
          end
        end
        MV_FIN: begin
          busy  <= 1'b0;
          state <= MV_IDLE;
        end
        default: state <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wsd_done_tally.sv
module wsd_done_tally #(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin,
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] words,
  output logic             irq,
  output logic [CNT_W-1:0] tally,
  output logic             evt_valid,
  output logic [AW-1:0]    evt_base,
  output logic [LEN_W-1:0] evt_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      tally     <= '0;
      evt_valid <= 1'b0;
      evt_base  <= '0;
      evt_len   <= '0;
    end else begin
      irq       <= fin;
      evt_valid <= fin;
      if (fin) begin
        tally    <= tally + CNT_W'(1);
        evt_base <= base;
        evt_len  <= words;
      end
    end
  end
endmodule

// File: rtl/wordstream_dma.sv
module wordstream_dma #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 32,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic             cfg_rd_en,
  input  logic [OFS_W-1:0] cfg_ofs,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic             cfg_rvalid,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [DW-1:0]    mem_rd_data,
  input  logic             mem_rd_valid,
  output logic             ep_valid,
  output logic [DW-1:0]    ep_data,
  output logic             ep_last,
  input  logic             ep_ready,
  output logic             busy,
  output logic             irq_done,
  output logic             evt_valid,
  output logic [AW-1:0]    evt_base,
  output logic [LEN_W-1:0] evt_len
);
  logic [AW-1:0]    base;
  logic [LEN_W-1:0] words;
  logic             start;
  logic             fin;
  logic [CNT_W-1:0] tally;

  wsd_cfg_regs #(.DW(DW), .AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .ofs(cfg_ofs), .wdata(cfg_wdata),
    .busy(busy), .tally(tally),
    .rdata(cfg_rdata), .rvalid(cfg_rvalid),
    .base(base), .words(words), .start(start)
  );

  wsd_mover #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_mover (
    .clk(clk), .rst(rst), .start(start), .base(base), .words(words),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .ep_valid(ep_valid), .ep_data(ep_data), .ep_last(ep_last), .ep_ready(ep_ready),
    .busy(busy), .fin(fin)
  );

  wsd_done_tally #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .fin(fin), .base(base), .words(words),
    .irq(irq_done), .tally(tally),
    .evt_valid(evt_valid), .evt_base(evt_base), .evt_len(evt_len)
  );
endmodule

// File: rtl/wsd_checks.sv
module wsd_checks #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_rd_en,
  input logic          cfg_rvalid,
  input logic          mem_rd_en,
  input logic          ep_valid,
  input logic [DW-1:0] ep_data,
  input logic          ep_last,
  input logic          ep_ready,
  input logic          busy,
  input logic          irq_done,
  input logic          evt_valid
);
  a_r1_read_answer: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_en |=> cfg_rvalid);

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (busy && !ep_valid));

  a_r3_request_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (ep_valid && !ep_ready) |=> (ep_valid && $stable(ep_data) && $stable(ep_last)));

  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    ep_last |-> ep_valid);

  a_r2_stream_in_job: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> busy);

  a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done);

  a_r5_irq_at_busy_fall: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> (!busy && $past(busy) && evt_valid));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !ep_valid && !mem_rd_en && !irq_done && !evt_valid));
endmodule

bind wordstream_dma wsd_checks #(.DW(DW)) u_chk (.*);

// File: tb/sim_wordstream_dma.sv
`timescale 1ns/1ps
module sim_wordstream_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [3:0]  cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        mem_rd_valid = 1'b0;
  logic        ep_valid, ep_last;
  logic [31:0] ep_data;
  logic        ep_ready = 1'b1;
  logic        busy, irq_done, evt_valid;
  logic [31:0] evt_base;
  logic [15:0] evt_len;

  always #10 clk = ~clk;

  wordstream_dma u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  int lat = 1, ready_mode = 0, pend = 0;
  int beats_job = 0;
  bit finished = 0;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  logic        m_busy = 0, m_rden = 0, m_epv = 0, m_epl = 0, m_irq = 0, m_evt = 0, m_rvalid = 0;
  logic [31:0] m_addr = 0, m_epd = 0, m_base = 0, m_rdata = 0, m_cnt = 0, m_ebase = 0;
  logic [15:0] m_len = 0, m_left = 0, m_elen = 0;
  int          m_phase = 0;
  logic [31:0] exp_q[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_rden = 0; m_epv = 0; m_epl = 0; m_irq = 0; m_evt = 0; m_rvalid = 0;
      m_addr = 0; m_epd = 0; m_base = 0; m_rdata = 0; m_cnt = 0; m_ebase = 0;
      m_len = 0; m_left = 0; m_elen = 0; m_phase = 0; exp_q.delete();
    end else begin
      bit go;
      if (ep_valid && ep_ready) begin
        logic [31:0] w;
        beats_job++;
        w = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hXXXX_XXXX;
        chk(ep_data === w, "R3 word order", ep_data, w);
        chk(ep_last == (exp_q.size() == 0), "R4 last on final word", 32'(ep_last), 32'(exp_q.size() == 0));
      end
      m_rvalid = cfg_rd_en;
      if (cfg_rd_en)
        case (cfg_ofs)
          4'h0: m_rdata = m_base;
          4'h4: m_rdata = {16'h0, m_len};
          4'h8: m_rdata = {31'h0, m_busy};
          4'hC: m_rdata = m_cnt;
          default: m_rdata = 32'h0;
        endcase
      go = cfg_wr_en && !m_busy && cfg_ofs == 4'h8 && cfg_wdata[0];
      m_irq = 0; m_evt = 0; m_rden = 0;
      case (m_phase)
        0: if (go) begin
          m_busy = 1; m_left = m_len; beats_job = 0;
          for (int i = 0; i < int'(m_len); i++) exp_q.push_back(mem_fn(m_base + 32'(4 * i)));
          if (m_len == 0) m_phase = 3;
          else begin m_phase = 1; m_rden = 1; m_addr = m_base; end
        end
        1: if (mem_rd_valid) begin
          m_epv = 1; m_epd = mem_rd_data; m_epl = (m_left == 1); m_phase = 2;
        end
        2: if (ep_ready) begin
          m_epv = 0; m_epl = 0;
          if (m_left == 1) m_phase = 3;
          else begin m_left--; m_addr += 4; m_rden = 1; m_phase = 1; end
        end
        default: begin
          m_busy = 0; m_irq = 1; m_evt = 1; m_cnt++;
          m_ebase = m_base; m_elen = m_len; m_phase = 0;
        end
      endcase
      if (cfg_wr_en && !m_busy && !go) begin
        if (cfg_ofs == 4'h0) m_base = cfg_wdata;
        if (cfg_ofs == 4'h4) m_len = cfg_wdata[15:0];
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(busy == m_busy, "R2 busy", 32'(busy), 32'(m_busy));
      chk(mem_rd_en == m_rden, "R3 request", 32'(mem_rd_en), 32'(m_rden));
      if (m_rden) chk(mem_rd_addr == m_addr, "R3 address", mem_rd_addr, m_addr);
      chk(ep_valid == m_epv, "R4 valid", 32'(ep_valid), 32'(m_epv));
      if (m_epv) begin
        chk(ep_data == m_epd, "R4 data", ep_data, m_epd);
        chk(ep_last == m_epl, "R4 last", 32'(ep_last), 32'(m_epl));
      end
      chk(irq_done == m_irq, "R5 irq", 32'(irq_done), 32'(m_irq));
      chk(evt_valid == m_evt, "R5 event", 32'(evt_valid), 32'(m_evt));
      if (m_evt) begin
        chk(evt_base == m_ebase, "R5 event base", evt_base, m_ebase);
        chk(evt_len == m_elen, "R5 event length", 32'(evt_len), 32'(m_elen));
      end
      chk(cfg_rvalid == m_rvalid, "R1 read valid", 32'(cfg_rvalid), 32'(m_rvalid));
      if (m_rvalid) chk(cfg_rdata == m_rdata, "R1 read data", cfg_rdata, m_rdata);
    end
  end

  // memory with adjustable latency and endpoint with adjustable ready
  always @(negedge clk) begin
    mem_rd_valid <= 1'b0;
    if (rst) pend = 0;
    else begin
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rd_valid <= 1'b1; mem_rd_data <= mem_fn(mem_rd_addr); end
      end
      if (mem_rd_en) pend = lat;
    end
    case (ready_mode)
      0: ep_ready <= 1'b1;
      1: ep_ready <= (cyc % 3 == 0);
      default: ep_ready <= (cyc % 5 > 1);
    endcase
  end

  task automatic wr(input logic [3:0] o, input logic [31:0] d);
    @(negedge clk); cfg_wr_en = 1; cfg_ofs = o; cfg_wdata = d;
    @(negedge clk); cfg_wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] o, output logic [31:0] d);
    @(negedge clk); cfg_rd_en = 1; cfg_ofs = o;
    @(negedge clk); cfg_rd_en = 0; d = cfg_rdata;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq_done && n < 5000) begin @(negedge clk); n++; end
    chk(irq_done, "R5 completion seen", 32'(irq_done), 32'h1);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk(!busy && !ep_valid && !mem_rd_en && !irq_done, "R8 reset state", {busy, ep_valid, mem_rd_en, irq_done}, 32'h0);
    rst = 0;
    rd(4'hC, d); chk(d == 0, "R8 tally after reset", d, 0);

    // job 1: five words, free-flowing endpoint
    wr(4'h0, 32'h0000_1000); wr(4'h4, 32'd5);
    rd(4'h0, d); chk(d == 32'h1000, "R1 base readback", d, 32'h1000);
    rd(4'h4, d); chk(d == 5, "R1 count readback", d, 5);
    rd(4'h2, d); chk(d == 0, "R1 unmapped offset", d, 0);
    wr(4'h8, 32'h1);
    rd(4'h8, d); chk(d == 1, "R1 control shows busy", d, 1);
    wait_irq();
    rd(4'hC, d); chk(d == 1, "R5 tally one", d, 1);

    // job 2: three words, slow memory and stalling endpoint; writes during busy
    lat = 3; ready_mode = 1;
    wr(4'h0, 32'h0000_2040); wr(4'h4, 32'd3); wr(4'h8, 32'h1);
    wr(4'h0, 32'hDEAD_BEEC); wr(4'h4, 32'd9); wr(4'h8, 32'h1);
    wait_irq();
    rd(4'h0, d); chk(d == 32'h2040, "R6 base kept during busy", d, 32'h2040);
    rd(4'h4, d); chk(d == 3, "R6 count kept during busy", d, 3);
    chk(beats_job == 3, "R6 no restart", beats_job, 3);
    rd(4'hC, d); chk(d == 2, "R5 tally two", d, 2);

    // job 3: zero length
    ready_mode = 2; lat = 2;
    wr(4'h4, 32'd0);
    @(negedge clk); cfg_wr_en = 1; cfg_ofs = 4'h8; cfg_wdata = 32'h1;
    @(negedge clk); cfg_wr_en = 0;
    chk(busy, "R7 busy after start", 32'(busy), 1);
    @(negedge clk);
    chk(irq_done, "R7 immediate completion", 32'(irq_done), 1);
    chk(beats_job == 0, "R7 no beats", beats_job, 0);
    rd(4'hC, d); chk(d == 3, "R7 tally counts empty job", d, 3);

    // control write without start bit
    wr(4'h8, 32'h0);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_rd_en, "R9 no start", 32'(busy), 0);

    // job 4: single word
    wr(4'h0, 32'h0000_0FFC); wr(4'h4, 32'd1); wr(4'h8, 32'h1);
    wait_irq();
    chk(beats_job == 1, "R4 single word job", beats_job, 1);

    // job 5: long job cut by reset
    ready_mode = 1; lat = 1;
    wr(4'h0, 32'h0000_3000); wr(4'h4, 32'd20); wr(4'h8, 32'h1);
    repeat (12) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk(!busy && !ep_valid, "R8 reset mid job", {busy, ep_valid}, 0);
    rd(4'hC, d); chk(d == 0, "R8 tally cleared", d, 0);
    rd(4'h4, d); chk(d == 0, "R8 count cleared", d, 0);
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired: actual hang expected completion");
    summary();
  end
endmodule